// File: doc/BRIEF.md
# ACPI Memory Power-State Sequencer

This block is a synchronous controller that follows a system's sleep status lines and decides which standby power rails are switched on. It tracks five power states: mechanical-off, soft-off with the dual rail off, soft-off with the dual rail on, full power and suspend-to-RAM. Two internal ramping states hold each powered transition pending until a digital soft-start counter reaches its terminal count. The block drives two enables for the dual rail, one for the main-supply switch and one for the standby switch. It also drives one enable per regulated rail, the soft-start count with its completion pulse, and an open-drain pulldown request for the power-good line.

All status inputs are asynchronous and pass through a synchronizer bank before the state logic uses them. A mode input selects the rail arrangement. In three-regulator mode every regulated rail is monitored, and the lowest-voltage rail starts ramping ahead of the others. In bus-termination mode all rail drivers start together and only the first rail is monitored. Regulation, the charge pump and output-voltage selection are analog matters and are not part of this block. The undervoltage comparators appear here as digital flags.

Top module: `mem_pwr_seq`

## Requirements
- R1: While reset is applied, state_o is 0 (mechanical-off) and every enable, ramp_done_o and pg_pull_o are 0. The state codes are: 0 mechanical-off, 1 soft-off rail-off, 2 ramp to rail-on, 3 soft-off rail-on, 4 ramp to full power, 5 full power, 6 suspend.
- R2: A change on any status input reaches state_o on the third rising clock edge after the change, and not on the second.
- R3: The block stays in state 0 while supply_ok_i is low. Once supply_ok_i is high it moves to state 1.
- R4: From state 1, the block enters state 2 when dual_en_n_i is low, or when both s3_n_i and s5_n_i are high. When the ramp completes it moves to state 3.
- R5: On entry to a ramp state, ss_count_o is cleared to 0. It then rises by one per cycle up to RAMP_LEN. ramp_done_o is high for exactly the one cycle in which the count equals RAMP_LEN, and the state advances on the next edge.
- R6: In state 3, the block enters state 4 when s3_n_i and s5_n_i are both high; this takes priority. Otherwise it returns to state 1 when dual_en_n_i is high.
- R7: In state 5, s5_n_i low moves the block to state 3. Otherwise, s3_n_i low moves it to state 6.
- R8: In state 6, s5_n_i low moves the block to state 3. The block returns to state 5 only when s3_n_i, s5_n_i and pgood_i are all high, and it stays in state 6 while pgood_i is low.
- R9: The outputs for each state are as follows. States 0 and 1: all enables are low. States 2 and 3: only dual_sb_en_o is high. State 4: dual_sb_en_o is high with the rails ramping. State 5: dual_main_en_o is high and all rails are on. State 6: dual_sb_en_o is high and all rails are on.
- R10: mode_i=1 selects three-regulator mode. In that mode rail_en_o[2] turns on at entry to state 4, and rails 0 and 1 turn on once ss_count_o reaches LEAD_CNT. mode_i=0 selects bus-termination mode, in which all rails turn on at entry to state 4.
- R11: pg_pull_o goes high on the third edge after a monitored undervoltage flag rises, and only in states 5 and 6. All of uv_i is monitored in mode 1; only uv_i[0] is monitored in mode 0. pg_pull_o is 0 in every other state.
- R12: A falling s5_n_i during a ramp aborts it. State 2 returns to state 1 and state 4 returns to state 3, on the same third edge as any other input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s3_n_i | input | 1 | Suspend status, active low |
| s5_n_i | input | 1 | Soft-off status, active low |
| dual_en_n_i | input | 1 | Standby dual-rail enable in soft-off, active low |
| pgood_i | input | 1 | External power-good level |
| supply_ok_i | input | 1 | Standby supply above its rising threshold |
| mode_i | input | 1 | 1 three-regulator mode, 0 bus-termination mode |
| uv_i | input | N_RAIL | Per-rail undervoltage flags |
| dual_main_en_o | output | 1 | Dual rail fed from the main-supply switch |
| dual_sb_en_o | output | 1 | Dual rail fed from the standby switch |
| rail_en_o | output | N_RAIL | Regulated rail enables |
| ss_count_o | output | CW | Soft-start ramp count |
| ramp_done_o | output | 1 | Ramp terminal-count pulse |
| pg_pull_o | output | 1 | Request to pull the power-good line low |
| state_o | output | 3 | Current state code |

## Verification
Every status input crosses two synchronizer flops and then the state register, so state changes and the per-state enables are due on the third rising edge after a stimulus. The bench drives on falling edges and samples after exactly two edges, where the old value must still hold, and again after the third. The pulldown request is registered after the same two synchronizer flops, so it is checked on the same third-edge schedule. Ramp timing is counted from the entry edge, one count per edge: the terminal pulse falls RAMP_LEN edges after entry, and the state advance follows one edge after that. The lagging rails join LEAD_CNT edges after entry. Table vectors hold each input pattern long enough for two back-to-back ramps to finish before the outputs are compared.

// File: rtl/mps_pkg.sv
package mps_pkg;

  typedef enum logic [2:0] {
    ST_G3    = 3'd0,
    ST_OFF   = 3'd1,
    ST_RUP   = 3'd2,
    ST_ON    = 3'd3,
    ST_RS0   = 3'd4,
    ST_FULL  = 3'd5,
    ST_SUSP  = 3'd6
  } pstate_e;

  function automatic logic is_ramp(input pstate_e s);
    return (s == ST_RUP) || (s == ST_RS0);
  endfunction

  function automatic logic is_monitored(input pstate_e s);
    return (s == ST_FULL) || (s == ST_SUSP);
  endfunction

endpackage

// File: rtl/mps_sync.sv
module mps_sync #(
  parameter int              W       = 8,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mps_ramp.sv
module mps_ramp #(
  parameter int RAMP_LEN = 1024,
  parameter int LEAD_CNT = 256,
  parameter int CW       = $clog2(RAMP_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o,
  output logic          lead_o
);

  localparam logic [CW-1:0] LIMIT = CW'(RAMP_LEN);
  localparam logic [CW-1:0] LEAD  = CW'(LEAD_CNT);

  logic [CW-1:0] cnt_q;
  logic          at_lim;
  logic          cnt_en;

  assign at_lim = (cnt_q == LIMIT);
  assign cnt_en = run_i && !at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign done_o = run_i && at_lim;
  assign lead_o = (cnt_q >= LEAD);

  // R5
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && !at_lim) |=> (cnt_q != '0));

endmodule

// File: rtl/mps_fsm.sv
module mps_fsm
  import mps_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    s3_s,
  input  logic    s5_s,
  input  logic    en_n_s,
  input  logic    pg_s,
  input  logic    sup_s,
  input  logic    done_i,
  output pstate_e st_o,
  output logic    clr_o
);

  pstate_e cur_q, nxt;
  logic    s5_prev_q;
  logic    s5_fall;
  logic    both_hi;

  assign s5_fall = s5_prev_q && !s5_s;
  assign both_hi = s3_s && s5_s;

  always_comb begin
    nxt = cur_q;
    unique case (cur_q)
      ST_G3:   if (sup_s) nxt = ST_OFF;
      ST_OFF:  if (!en_n_s || both_hi) nxt = ST_RUP;
      ST_RUP: begin
        if (s5_fall)     nxt = ST_OFF;
        else if (done_i) nxt = ST_ON;
      end
      ST_ON: begin
        if (both_hi)     nxt = ST_RS0;
        else if (en_n_s) nxt = ST_OFF;
      end
      ST_RS0: begin
        if (s5_fall)     nxt = ST_ON;
        else if (done_i) nxt = ST_FULL;
      end
      ST_FULL: begin
        if (!s5_s)       nxt = ST_ON;
        else if (!s3_s)  nxt = ST_SUSP;
      end
      ST_SUSP: begin
        if (!s5_s)            nxt = ST_ON;
        else if (s3_s && pg_s) nxt = ST_FULL;
      end
      default: nxt = ST_G3;
    endcase
  end

  assign clr_o = is_ramp(nxt) && !is_ramp(cur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= ST_G3;
      s5_prev_q <= 1'b1;
    end else begin
      cur_q     <= nxt;
      s5_prev_q <= s5_s;
    end
  end

  assign st_o = cur_q;

  // R3
  g3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_G3 && !sup_s) |=> (cur_q == ST_G3));

  // R8
  wake_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_SUSP && !pg_s) |=> (cur_q != ST_FULL));

  // R5
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_RS0 && !done_i && !s5_fall) |=> (cur_q == ST_RS0));

endmodule

// File: rtl/mps_drive.sv
module mps_drive
  import mps_pkg::*;
#(
  parameter int N_RAIL   = 3,
  parameter int LOW_RAIL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pstate_e           st_i,
  input  logic              mode_s,
  input  logic              lead_i,
  input  logic [N_RAIL-1:0] uv_s,
  output logic              main_en_o,
  output logic              sb_en_o,
  output logic [N_RAIL-1:0] rail_en_o,
  output logic              pull_o
);

  logic [N_RAIL-1:0] mon_mask;
  logic              rails_full;
  logic              rails_ramp;
  logic              pull_d, pull_q;

  assign rails_full = is_monitored(st_i);
  assign rails_ramp = (st_i == ST_RS0);

  assign main_en_o = (st_i == ST_FULL);
  assign sb_en_o   = (st_i == ST_RUP) || (st_i == ST_ON) ||
                     (st_i == ST_RS0) || (st_i == ST_SUSP);

  genvar r;
  generate
    for (r = 0; r < N_RAIL; r++) begin : g_rail
      if (r == LOW_RAIL) begin : g_lead
        assign rail_en_o[r] = rails_full || rails_ramp;
      end else begin : g_lag
        assign rail_en_o[r] = rails_full || (rails_ramp && (!mode_s || lead_i));
      end
      if (r == 0) begin : g_mon0
        assign mon_mask[r] = 1'b1;
      end else begin : g_monn
        assign mon_mask[r] = mode_s;
      end
    end
  endgenerate

  assign pull_d = rails_full && |(uv_s & mon_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_q <= 1'b0;
    else        pull_q <= pull_d;
  end

  assign pull_o = pull_q;

  // R9
  one_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({main_en_o, sb_en_o}));

  // R11
  pull_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_monitored(st_i) |=> !pull_o);

endmodule

// File: rtl/mem_pwr_seq.sv
module mem_pwr_seq
  import mps_pkg::*;
#(
  parameter int N_RAIL      = 3,
  parameter int RAMP_LEN    = 1024,
  parameter int LEAD_CNT    = 256,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_RAIL    = 2,
  localparam int CW         = $clog2(RAMP_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s3_n_i,
  input  logic              s5_n_i,
  input  logic              dual_en_n_i,
  input  logic              pgood_i,
  input  logic              supply_ok_i,
  input  logic              mode_i,
  input  logic [N_RAIL-1:0] uv_i,
  output logic              dual_main_en_o,
  output logic              dual_sb_en_o,
  output logic [N_RAIL-1:0] rail_en_o,
  output logic [CW-1:0]     ss_count_o,
  output logic              ramp_done_o,
  output logic              pg_pull_o,
  output logic [2:0]        state_o
);

  localparam int SW = N_RAIL + 6;
  localparam logic [SW-1:0] SYNC_RST = {{N_RAIL{1'b0}}, 6'b000111};

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [SW-1:0] raw_vec, syn_vec;
  logic          s3_s, s5_s, en_n_s, pg_s, sup_s, mode_s;
  logic [N_RAIL-1:0] uv_s;
  pstate_e       st;
  logic          clr, done, lead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_vec = {uv_i, mode_i, supply_ok_i, pgood_i, dual_en_n_i, s5_n_i, s3_n_i};

  mps_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  (raw_vec),
    .q_o  (syn_vec)
  );

  assign s3_s   = syn_vec[0];
  assign s5_s   = syn_vec[1];
  assign en_n_s = syn_vec[2];
  assign pg_s   = syn_vec[3];
  assign sup_s  = syn_vec[4];
  assign mode_s = syn_vec[5];
  assign uv_s   = syn_vec[SW-1:6];

  mps_fsm i_fsm (
    .clk   (clk),
    .rst_n (rst_int_n),
    .s3_s  (s3_s),
    .s5_s  (s5_s),
    .en_n_s(en_n_s),
    .pg_s  (pg_s),
    .sup_s (sup_s),
    .done_i(done),
    .st_o  (st),
    .clr_o (clr)
  );

  mps_ramp #(.RAMP_LEN(RAMP_LEN), .LEAD_CNT(LEAD_CNT), .CW(CW)) i_ramp (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr_i (clr),
    .run_i (is_ramp(st)),
    .cnt_o (ss_count_o),
    .done_o(done),
    .lead_o(lead)
  );

  mps_drive #(.N_RAIL(N_RAIL), .LOW_RAIL(LOW_RAIL)) i_drive (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .st_i     (st),
    .mode_s   (mode_s),
    .lead_i   (lead),
    .uv_s     (uv_s),
    .main_en_o(dual_main_en_o),
    .sb_en_o  (dual_sb_en_o),
    .rail_en_o(rail_en_o),
    .pull_o   (pg_pull_o)
  );

  assign ramp_done_o = done;
  assign state_o     = st;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ramp_done_o |=> !ramp_done_o);

  // R9
  rails_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st == ST_OFF || st == ST_G3) |-> (rail_en_o == '0 && !dual_sb_en_o));

endmodule

// File: tb/test_mem_pwr_seq.sv
`timescale 1ns/1ps
module test_mem_pwr_seq;

  localparam int NR = 3;
  localparam int RL = 8;
  localparam int LC = 3;
  localparam int CW = $clog2(RL + 1);
  localparam int HOLD = 30;

  // [11]s3_n [10]s5_n [9]en_n [8]pgood [7:5]state [4]main [3]sb [2:0]rails
  localparam logic [11:0] VEC [0:7] = '{
    12'b0000_011_0_1_000,
    12'b0010_001_0_0_000,
    12'b1110_101_1_0_111,
    12'b0110_110_0_1_111,
    12'b1110_110_0_1_111,
    12'b1111_101_1_0_111,
    12'b1001_011_0_1_000,
    12'b0011_001_0_0_000
  };

  logic clk = 1'b0;
  logic rst_n, s3_n, s5_n, en_n, pg, sup, mode;
  logic [NR-1:0] uv;
  logic main_en, sb_en, done, pull;
  logic [NR-1:0] rails;
  logic [CW-1:0] cnt;
  logic [2:0] st;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  mem_pwr_seq #(.N_RAIL(NR), .RAMP_LEN(RL), .LEAD_CNT(LC)) i_mem_pwr_seq (
    .clk(clk), .rst_n(rst_n), .s3_n_i(s3_n), .s5_n_i(s5_n), .dual_en_n_i(en_n),
    .pgood_i(pg), .supply_ok_i(sup), .mode_i(mode), .uv_i(uv),
    .dual_main_en_o(main_en), .dual_sb_en_o(sb_en), .rail_en_o(rails),
    .ss_count_o(cnt), .ramp_done_o(done), .pg_pull_o(pull), .state_o(st)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; s3_n = 1'b0; s5_n = 1'b0; en_n = 1'b1; pg = 1'b0;
    sup = 1'b0; mode = 1'b1; uv = '0;
    repeat (3) @(negedge clk);
    chk("R1 state", st, 0);
    chk("R1 enables", {main_en, sb_en, rails, done, pull}, 0);
    rst_n = 1'b1;
    tick(10);
    chk("R3 hold G3", st, 0);
    sup = 1'b1;
    tick(2);
    chk("R2 not yet", st, 0);
    tick(1);
    chk("R3 to soft-off", st, 1);

    // table walk
    for (int i = 0; i < 8; i++) begin
      {s3_n, s5_n, en_n, pg} = VEC[i][11:8];
      tick(HOLD);
      chk($sformatf("R9 vec%0d state", i), st, VEC[i][7:5]);
      chk($sformatf("R9 vec%0d main", i), main_en, VEC[i][4]);
      chk($sformatf("R9 vec%0d sb", i), sb_en, VEC[i][3]);
      chk($sformatf("R9 vec%0d rails", i), rails, VEC[i][2:0]);
    end

    // R4 / R5: precise ramp from soft-off rail-off
    en_n = 1'b0;
    tick(2);
    chk("R2 ramp not yet", st, 1);
    tick(1);
    chk("R4 enter ramp", st, 2);
    chk("R5 count cleared", cnt, 0);
    chk("R9 ramp sb only", {main_en, sb_en, rails}, 5'b01000);
    tick(RL - 1);
    chk("R5 count below", cnt, RL - 1);
    chk("R5 no early done", done, 0);
    tick(1);
    chk("R5 terminal", cnt, RL);
    chk("R5 done pulse", done, 1);
    tick(1);
    chk("R4 rail-on reached", st, 3);
    chk("R5 done cleared", done, 0);

    // R10 / R6: staggered ramp to full power
    s3_n = 1'b1; s5_n = 1'b1;
    tick(3);
    chk("R6 enter ramp2", st, 4);
    chk("R10 lead rail only", rails, 3'b100);
    tick(LC - 1);
    chk("R10 still lead", rails, 3'b100);
    tick(1);
    chk("R10 all rails", rails, 3'b111);
    tick(RL);
    chk("R7 full power", st, 5);

    // R11 three-regulator monitoring
    uv = 3'b010;
    tick(2);
    chk("R11 pull not yet", pull, 0);
    tick(1);
    chk("R11 pull rail1", pull, 1);
    uv = '0;
    tick(3);
    chk("R11 pull released", pull, 0);

    // R12 abort of ramp to full power
    s5_n = 1'b0;
    tick(4);
    chk("R7 to rail-on", st, 3);
    s5_n = 1'b1;
    tick(4);
    chk("R12 in ramp2", st, 4);
    s5_n = 1'b0;
    tick(2);
    chk("R12 not yet", st, 4);
    tick(1);
    chk("R12 aborted", st, 3);

    // bus-termination mode
    mode = 1'b0;
    tick(4);
    s5_n = 1'b1;
    tick(3);
    chk("R10 bus mode all rails", rails, 3'b111);
    tick(RL + 1);
    chk("R10 full power bus", st, 5);
    uv = 3'b010;
    tick(5);
    chk("R11 rail1 unmonitored", pull, 0);
    uv = 3'b001;
    tick(3);
    chk("R11 rail0 monitored", pull, 1);
    s5_n = 1'b0;
    tick(5);
    chk("R7 back rail-on", st, 3);
    chk("R11 ignored rail-on", pull, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule